// File: doc/BRIEF.md
# LIN Master Header Generator

This block produces the opening header that the single master of a LIN network puts on the bus before any response. A one-cycle start request with a 6-bit identifier makes it send four things in turn on a serial output. First comes a long dominant break, then a recessive delimiter bit. Next comes a synchronisation character holding 0x55. Last comes a protected identifier character made of the six identifier bits and two parity bits. Each character uses UART framing.

The bit rate comes from a clock-divider input. One bit lasts `div_i + 1` clock cycles, which covers 20 kbit/s and slower rates from any practical system clock. The divider and the identifier are captured when the request is accepted, so the header is not affected by later changes on those inputs. A busy flag covers the whole header. A one-cycle done pulse marks its end, and the next header may be requested in that same cycle.

Top module: `lin_hdr_gen`

## Requirements
- R1: After reset, and whenever no header is in progress, `tx_o` is 1 (recessive), `busy_o` is 0 and `done_o` is 0.
- R2: A start request that is accepted at a clock edge drives `tx_o` to 0 from the next cycle. `tx_o` then stays 0 for BRK_BITS bit times, where BRK_BITS is a parameter of at least 13 (default 13).
- R3: The break is followed by exactly one bit time of `tx_o` = 1 (the delimiter).
- R4: The sync character follows the delimiter: a 0 start bit, the eight bits of 0x55 least significant bit first, and a 1 stop bit.
- R5: The identifier character follows the sync character. Its framing is a 0 start bit, then data bits ID0..ID5 (`id_i[0]` first), P0 = ID0^ID1^ID2^ID4 and P1 = ~(ID1^ID3^ID4^ID5), then a 1 stop bit.
- R6: Every bit lasts `div_i + 1` clock cycles. The value of `div_i` at the accepting edge is used for the whole header (0 gives one-cycle bits).
- R7: A start request while `busy_o` is 1 is ignored. Neither the bits being sent nor their timing change.
- R8: `busy_o` is 1 from the cycle after acceptance through the last cycle of the identifier stop bit. `done_o` is 1 for exactly the following cycle, in which `busy_o` is 0.
- R9: A start request in the cycle where `done_o` is 1 is accepted and begins a new header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Header request, sampled at the rising edge |
| id_i | input | 6 | Identifier bits ID0..ID5, captured on acceptance |
| div_i | input | DIV_W | Bit-time divider; one bit is `div_i + 1` cycles |
| tx_o | output | 1 | Serial bus output, 1 = recessive |
| busy_o | output | 1 | Header in progress |
| done_o | output | 1 | One-cycle end-of-header pulse |

## Verification
The checker watches several properties on every cycle. The line must be recessive whenever the block is not busy. The done pulse must last one cycle, must follow a busy cycle and must coincide with busy being low. Busy may only rise after a start request. The bit-level content of the header is checked only by the bench scenarios. Those scenarios compare every cycle of the output against a stream computed from the identifier and divider: break length, delimiter width, the sync pattern, identifier parity for several identifiers, the minimum divider, an ignored mid-header request together with a divider change, and a request placed in the done cycle.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_BREAK,
      PH_DELIM,
      PH_SYNC,
      PH_IDENT
   } phase_t;

   localparam logic [7:0] SYNC_BYTE  = 8'h55;
   localparam int         FRAME_LAST = 9;   // start + 8 data + stop, index 0..9
   localparam int         BRK_MIN    = 13;

   // Protected identifier: six identifier bits with two mixed parity bits on top.
   function automatic logic [7:0] protect_id(input logic [5:0] id);
      logic p0, p1;
      p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
      p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
      return {p1, p0, id};
   endfunction

   // Level of one character slot: 0 start bit, data LSB first, 1 stop bit.
   function automatic logic char_bit(input logic [7:0] data, input logic [3:0] idx);
      logic v;
      if (idx == 4'd0)
         v = 1'b0;
      else if (idx >= 4'(FRAME_LAST))
         v = 1'b1;
      else
         v = data[idx - 4'd1];
      return v;
   endfunction

endpackage

// File: rtl/lin_id_protect.sv
module lin_id_protect
   import lin_hdr_pkg::*;
(
   input  logic [5:0] id_i,
   output logic [7:0] pid_o
);

   always_comb pid_o = protect_id(id_i);

endmodule

// File: rtl/lin_bit_timer.sv
module lin_bit_timer #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             run_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         div_q <= div_i;
         cnt_q <= div_i;
      end else if (run_i) begin
         if (cnt_q == '0)
            cnt_q <= div_q;
         else
            cnt_q <= cnt_q - 1'b1;
      end
   end

   assign tick_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
   import lin_hdr_pkg::*;
#(
   parameter int BRK_BITS = 13,
   parameter int IDX_W    = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [7:0] pid_i,
   input  logic       tick_i,
   output logic       accept_o,
   output logic       tx_o,
   output logic       busy_o,
   output logic       done_o
);

   localparam logic [IDX_W-1:0] BRK_LAST = IDX_W'(BRK_BITS - 1);
   localparam logic [IDX_W-1:0] CHR_LAST = IDX_W'(FRAME_LAST);

   phase_t           phase_q;
   logic [IDX_W-1:0] idx_q;
   logic [7:0]       pid_q;
   logic             done_q;

   assign accept_o = start_i && (phase_q == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
         pid_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept_o) begin
            phase_q <= PH_BREAK;
            idx_q   <= '0;
            pid_q   <= pid_i;
         end else if (tick_i) begin
            unique case (phase_q)
               PH_BREAK: begin
                  if (idx_q == BRK_LAST) begin
                     phase_q <= PH_DELIM;
                     idx_q   <= '0;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
               PH_DELIM: begin
                  phase_q <= PH_SYNC;
                  idx_q   <= '0;
               end
               PH_SYNC: begin
                  if (idx_q == CHR_LAST) begin
                     phase_q <= PH_IDENT;
                     idx_q   <= '0;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
               PH_IDENT: begin
                  if (idx_q == CHR_LAST) begin
                     phase_q <= PH_IDLE;
                     idx_q   <= '0;
                     done_q  <= 1'b1;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (phase_q)
         PH_BREAK: tx_o = 1'b0;
         PH_DELIM: tx_o = 1'b1;
         PH_SYNC:  tx_o = char_bit(SYNC_BYTE, idx_q[3:0]);
         PH_IDENT: tx_o = char_bit(pid_q, idx_q[3:0]);
         default:  tx_o = 1'b1;
      endcase
   end

   assign busy_o = (phase_q != PH_IDLE);
   assign done_o = done_q;

endmodule

// File: rtl/lin_hdr_gen.sv
module lin_hdr_gen
   import lin_hdr_pkg::*;
#(
   parameter int DIV_W    = 16,
   parameter int BRK_BITS = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [5:0]       id_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tx_o,
   output logic             busy_o,
   output logic             done_o
);

   localparam int BRK_IDX_W = (BRK_BITS > 1) ? $clog2(BRK_BITS) : 1;
   localparam int IDX_W     = (BRK_IDX_W > 4) ? BRK_IDX_W : 4;

   generate
      if (BRK_BITS < BRK_MIN) begin : g_brk_too_short
         $error("lin_hdr_gen: BRK_BITS must be at least 13");
      end
      if (DIV_W < 1) begin : g_div_too_narrow
         $error("lin_hdr_gen: DIV_W must be at least 1");
      end
   endgenerate

   logic [7:0] pid;
   logic       accept;
   logic       tick;

   lin_id_protect u_protect (
      .id_i  (id_i),
      .pid_o (pid)
   );

   lin_bit_timer #(.DIV_W(DIV_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .div_i  (div_i),
      .run_i  (busy_o),
      .tick_o (tick)
   );

   lin_hdr_seq #(.BRK_BITS(BRK_BITS), .IDX_W(IDX_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .pid_i    (pid),
      .tick_i   (tick),
      .accept_o (accept),
      .tx_o     (tx_o),
      .busy_o   (busy_o),
      .done_o   (done_o)
   );

endmodule

// File: rtl/lin_hdr_chk.sv
module lin_hdr_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic tx_o,
   input logic busy_o,
   input logic done_o
);

   // R1
   idle_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> tx_o);

   // R8
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(busy_o));

   // R2
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   // R2
   break_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !tx_o);

endmodule

bind lin_hdr_gen lin_hdr_chk u_lin_hdr_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .tx_o    (tx_o),
   .busy_o  (busy_o),
   .done_o  (done_o)
);

// File: tb/lin_hdr_gen_bench.sv
module lin_hdr_gen_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DIV_W      = 16;
   localparam int BRK_BITS   = 13;
   localparam int HDR_BITS   = BRK_BITS + 1 + 20;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [5:0]       id_i = '0;
   logic [DIV_W-1:0] div_i = '0;
   logic             tx_o, busy_o, done_o;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  pending  = 0;
   bit  finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lin_hdr_gen #(.DIV_W(DIV_W), .BRK_BITS(BRK_BITS)) u_lin_hdr_gen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .id_i(id_i),
      .div_i(div_i), .tx_o(tx_o), .busy_o(busy_o), .done_o(done_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_pid(input logic [5:0] id);
      logic p0, p1;
      p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
      p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
      return {p1, p0, id};
   endfunction

   function automatic logic chr(input logic [7:0] b, input int k);
      if (k == 0) return 1'b0;
      if (k == 9) return 1'b1;
      return b[k-1];
   endfunction

   // Expected line level for bit slot j of a header.
   function automatic logic exp_bit(input int j, input logic [5:0] id);
      if (j < BRK_BITS)      return 1'b0;
      if (j == BRK_BITS)     return 1'b1;
      if (j < BRK_BITS + 11) return chr(8'h55, j - BRK_BITS - 1);
      return chr(exp_pid(id), j - BRK_BITS - 11);
   endfunction

   // One header, compared cycle by cycle. inj: mid-header start with other id and divider.
   // chain: raise start in the done cycle for the next call.
   task automatic run_hdr(input logic [5:0] id, input int dv, input bit inj,
                          input bit chain, input logic [5:0] nid, input string tag);
      int n, bt;
      int err_brk, err_del, err_syn, err_idn, err_bsy;
      int bad_act, bad_exp;
      bt = dv + 1;
      n  = HDR_BITS * bt;
      err_brk = 0; err_del = 0; err_syn = 0; err_idn = 0; err_bsy = 0;
      bad_act = 0; bad_exp = 0;
      if (!pending) begin
         @(negedge clk);
         div_i = DIV_W'(dv); id_i = id; start_i = 1'b1;
      end
      pending = 0;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      for (int c = 0; c < n; c++) begin
         int j;
         logic e;
         j = c / bt;
         e = exp_bit(j, id);
         if (tx_o !== e) begin
            bad_act = tx_o; bad_exp = e;
            if (j < BRK_BITS) err_brk++;
            else if (j == BRK_BITS) err_del++;
            else if (j < BRK_BITS + 11) err_syn++;
            else err_idn++;
         end
         if (busy_o !== 1'b1 || done_o !== 1'b0) err_bsy++;
         if (inj && c == n/2) begin
            start_i = 1'b1; id_i = ~id; div_i = DIV_W'(dv + 5);
         end
         if (inj && c == n/2 + 1) start_i = 1'b0;
         @(negedge clk);
      end
      check(err_brk == 0, inj ? "R7" : "R2", {tag, " break cycles wrong"}, err_brk, 0);
      check(err_del == 0, "R3", {tag, " delimiter cycles wrong"}, err_del, 0);
      check(err_syn == 0, "R4", {tag, " sync cycles wrong"}, err_syn, 0);
      check(err_idn == 0, inj ? "R7" : "R5", {tag, " ident cycles wrong"}, err_idn, 0);
      if (err_brk + err_del + err_syn + err_idn != 0)
         $display("  last mismatch tx %0d expected %0d", bad_act, bad_exp);
      check(err_bsy == 0, "R8", {tag, " busy/done during header"}, err_bsy, 0);
      check(done_o === 1'b1 && busy_o === 1'b0 && tx_o === 1'b1, "R8",
            {tag, " done cycle {done,busy,tx}"}, {done_o, busy_o, tx_o}, 3'b101);
      if (chain) begin
         start_i = 1'b1; id_i = nid; div_i = DIV_W'(dv);
         pending = 1;
      end else begin
         @(negedge clk);
         check(done_o === 1'b0 && busy_o === 1'b0, "R8", {tag, " done lasts one cycle"},
               {done_o, busy_o}, 0);
      end
   endtask

   task automatic t_reset;
      check(tx_o === 1'b1, "R1", "reset tx", tx_o, 1);
      check(busy_o === 1'b0, "R1", "reset busy", busy_o, 0);
      check(done_o === 1'b0, "R1", "reset done", done_o, 0);
   endtask

   task automatic t_basic;      // R2 R3 R4 R5 R6
      run_hdr(6'h00, 3, 0, 0, 6'h00, "id00 div3");
   endtask

   task automatic t_all_ones;   // R5 parity with all id bits set
      run_hdr(6'h3F, 1, 0, 0, 6'h00, "id3F div1");
   endtask

   task automatic t_min_div;    // R6 one-cycle bits
      run_hdr(6'h15, 0, 0, 0, 6'h00, "id15 div0");
   endtask

   task automatic t_ignore;     // R7 request and divider change mid-header
      run_hdr(6'h2A, 2, 1, 0, 6'h00, "id2A ignore");
      check(tx_o === 1'b1 && busy_o === 1'b0, "R7", "no header started by ignored request",
            {tx_o, busy_o}, 2'b10);
   endtask

   task automatic t_chain;      // R9 request in the done cycle
      run_hdr(6'h11, 2, 0, 1, 6'h3C, "id11 chain");
      @(negedge clk);
      check(busy_o === 1'b1 && tx_o === 1'b0, "R9", "start in done cycle accepted",
            {busy_o, tx_o}, 2'b10);
      start_i = 1'b0;
      // finish the chained header by its full length, then confirm idle
      repeat (HDR_BITS * 3) @(negedge clk);
      check(done_o === 1'b1, "R9", "chained header done", done_o, 1);
      @(negedge clk);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_all_ones();
      t_min_div();
      t_ignore();
      t_chain();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule